// File: doc/BRIEF.md
# Timer Compare Interrupt Generator

This block keeps two running totals for a processor core: a wide cycle counter and a narrower count register. Both advance by a variable step, the number of instructions retired in an update, whenever the advance strobe is valid. A compare register holds a threshold. When an advance carries the count from below the threshold to at or beyond it, the block raises a timer pending flag. Because the step can be larger than one, the block detects a crossing rather than an equality match. It also treats an addition that overflows the count width as a crossing, provided the count started below the threshold.

Software may load the count and the compare register directly. A compare load also clears the pending flag, and a separate clear strobe does the same. The flag is merged into a vector of interrupt pending bits at a fixed index, and the other bits pass through unchanged. Masking and delivery of the interrupt happen downstream. The asynchronous active-low reset is released synchronously inside the block.

Top module: `timer_cmp_irq`

## Requirements
- R1: After reset, the cycle counter, count, compare and timer pending flag all read zero.
- R2: In a cycle with adv_valid high, the cycle counter advances by adv_amt modulo 2^64 and the count advances by adv_amt modulo 2^32. When adv_valid is low, both hold. Results are visible after the clock edge.
- R3: An advance sets the pending flag when the old count is below compare and the new count is at or above compare.
- R4: An advance also sets the pending flag when the old count is below compare and the addition overflows 32 bits, that is when old count > 2^32-1-adv_amt, even if the new count is below compare.
- R5: An advance whose old count is at or above compare never sets the pending flag, whether or not it overflows.
- R6: Once set, the pending flag stays set until pend_clr is high or compare is written. A crossing in the same cycle as a clear wins, and the flag stays set.
- R7: When cnt_wr_en and adv_valid are both high, the count takes cnt_wr_data, no crossing check is made, and the cycle counter still advances.
- R8: cmp_wr_en loads compare from cmp_wr_data, and cnt_wr_en loads count from cnt_wr_data, at the next clock edge.
- R9: irq_pend_o equals irq_pend_i with bit 7 (the timer index) replaced by the timer pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_valid | input | 1 | Advance strobe |
| adv_amt | input | 8 | Advance step |
| cnt_wr_en | input | 1 | Count load enable |
| cnt_wr_data | input | 32 | Count load value |
| cmp_wr_en | input | 1 | Compare load enable (also clears the flag) |
| cmp_wr_data | input | 32 | Compare load value |
| pend_clr | input | 1 | Pending flag clear |
| irq_pend_i | input | 8 | Other interrupt pending bits |
| cycle_o | output | 64 | Cycle counter |
| count_o | output | 32 | Count register |
| compare_o | output | 32 | Compare register |
| timer_pend_o | output | 1 | Timer pending flag |
| irq_pend_o | output | 8 | Merged pending vector |

## Verification
The bench drives the count to just below the 32-bit limit with large steps. A design that relied on the new count alone would miss an overflowing crossing (R4), while one that ignored the old-count condition would fire spuriously after an overflow (R5). It also lands steps exactly on compare and one short of it, which exposes an off-by-one comparison. It collides count loads with advances, where a wrong design would fire or drop the load. It collides clears with crossings, where a wrong design would lose the event.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned CNT_W_DEF   = 32;
  localparam int unsigned ADV_W_DEF   = 8;
  localparam int unsigned CYC_W_DEF   = 64;
  localparam int unsigned IRQ_N_DEF   = 8;
  localparam int unsigned TIMER_IDX_DEF = 7;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_ADV  = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/timer_rst_sync.sv
module timer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/timer_cycle_ctr.sv
module timer_cycle_ctr #(
  parameter int unsigned CYC_W = 64,
  parameter int unsigned ADV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_valid,
  input  logic [ADV_W-1:0] adv_amt,
  output logic [CYC_W-1:0] cycle_q
);
  logic [CYC_W-1:0] cycle_d;
  logic             cycle_en;

  always_comb begin
    cycle_en = adv_valid;
    cycle_d  = cycle_q + CYC_W'(adv_amt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cycle_q <= '0;
    else if (cycle_en) cycle_q <= cycle_d;
  end

  assert_cycle_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_valid |=> cycle_q == $past(cycle_q) + CYC_W'($past(adv_amt)));
  assert_cycle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_valid |=> $stable(cycle_q));
endmodule

// File: rtl/timer_count_unit.sv
module timer_count_unit
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned ADV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_valid,
  input  logic [ADV_W-1:0] adv_amt,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] compare_q,
  output logic             cross_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  cnt_op_e          op;
  logic [CNT_W-1:0] amt_ext;
  logic [CNT_W-1:0] count_d;
  logic             count_en;
  logic             below;
  logic             reach;
  logic             wraps;

  always_comb begin
    amt_ext = CNT_W'(adv_amt);
    if (cnt_wr_en)      op = CNT_LOAD;
    else if (adv_valid) op = CNT_ADV;
    else                op = CNT_HOLD;

    count_en = (op != CNT_HOLD);
    case (op)
      CNT_LOAD: count_d = cnt_wr_data;
      CNT_ADV:  count_d = count_q + amt_ext;
      default:  count_d = count_q;
    endcase

    below     = count_q < compare_q;
    reach     = (count_q + amt_ext) >= compare_q;
    wraps     = count_q > (CNT_MAX - amt_ext);
    cross_hit = (op == CNT_ADV) && below && (reach || wraps);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         compare_q <= '0;
    else if (cmp_wr_en) compare_q <= cmp_wr_data;
  end

  assert_count_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> count_q == $past(cnt_wr_data));
  assert_cmp_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_en |=> compare_q == $past(cmp_wr_data));
  assert_no_hit_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q >= compare_q) |-> !cross_hit);
  assert_no_hit_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |-> !cross_hit);
endmodule

// File: rtl/timer_pend_flag.sv
module timer_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_q
);
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = set_i | clr_i;
    pend_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i) |=> pend_q);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q);
endmodule

// File: rtl/timer_cmp_irq.sv
module timer_cmp_irq
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W     = CNT_W_DEF,
  parameter int unsigned ADV_W     = ADV_W_DEF,
  parameter int unsigned CYC_W     = CYC_W_DEF,
  parameter int unsigned IRQ_N     = IRQ_N_DEF,
  parameter int unsigned TIMER_IDX = TIMER_IDX_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_valid,
  input  logic [ADV_W-1:0] adv_amt,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic             pend_clr,
  input  logic [IRQ_N-1:0] irq_pend_i,
  output logic [CYC_W-1:0] cycle_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] compare_o,
  output logic             timer_pend_o,
  output logic [IRQ_N-1:0] irq_pend_o
);
  logic rst_n_sync;
  logic cross_hit;
  logic clr_any;

  timer_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  timer_cycle_ctr #(.CYC_W(CYC_W), .ADV_W(ADV_W)) u_cyc (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .adv_valid (adv_valid),
    .adv_amt   (adv_amt),
    .cycle_q   (cycle_o)
  );

  timer_count_unit #(.CNT_W(CNT_W), .ADV_W(ADV_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .adv_valid   (adv_valid),
    .adv_amt     (adv_amt),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .cmp_wr_en   (cmp_wr_en),
    .cmp_wr_data (cmp_wr_data),
    .count_q     (count_o),
    .compare_q   (compare_o),
    .cross_hit   (cross_hit)
  );

  assign clr_any = pend_clr | cmp_wr_en;

  timer_pend_flag u_pend (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .set_i  (cross_hit),
    .clr_i  (clr_any),
    .pend_q (timer_pend_o)
  );

  for (genvar g = 0; g < IRQ_N; g++) begin : g_merge
    if (g == TIMER_IDX) begin : g_timer
      assign irq_pend_o[g] = timer_pend_o;
    end else begin : g_pass
      assign irq_pend_o[g] = irq_pend_i[g];
    end
  end

  assert_load_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cnt_wr_en && !timer_pend_o) |=> !timer_pend_o);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (clr_any && !cross_hit) |=> !timer_pend_o);
  assert_merge_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    irq_pend_o[TIMER_IDX] == timer_pend_o);
endmodule

// File: tb/timer_cmp_irq_tb.sv
module timer_cmp_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_valid = 1'b0;
  logic [7:0]  adv_amt = '0;
  logic        cnt_wr_en = 1'b0;
  logic [31:0] cnt_wr_data = '0;
  logic        cmp_wr_en = 1'b0;
  logic [31:0] cmp_wr_data = '0;
  logic        pend_clr = 1'b0;
  logic [7:0]  irq_pend_i = '0;
  logic [63:0] cycle_o;
  logic [31:0] count_o;
  logic [31:0] compare_o;
  logic        timer_pend_o;
  logic [7:0]  irq_pend_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] m_cyc;
  logic [31:0] m_cnt;
  logic [31:0] m_cmp;
  logic        m_pend;

  always #10 clk = ~clk;

  timer_cmp_irq dut_i (
    .clk(clk), .rst_n(rst_n), .adv_valid(adv_valid), .adv_amt(adv_amt),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cmp_wr_en(cmp_wr_en),
    .cmp_wr_data(cmp_wr_data), .pend_clr(pend_clr), .irq_pend_i(irq_pend_i),
    .cycle_o(cycle_o), .count_o(count_o), .compare_o(compare_o),
    .timer_pend_o(timer_pend_o), .irq_pend_o(irq_pend_o)
  );

  function automatic logic crosses(logic [31:0] old, logic [7:0] amt, logic [31:0] cmp);
    logic [32:0] sum;
    sum = {1'b0, old} + {25'd0, amt};
    return (old < cmp) && ((sum[31:0] >= cmp) || sum[32]);
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [7:0] exp_irq;
    exp_irq = irq_pend_i;
    exp_irq[7] = m_pend;
    chk({tag, " R2 cycle"}, cycle_o, m_cyc);
    chk({tag, " R8 count"}, {32'd0, count_o}, {32'd0, m_cnt});
    chk({tag, " R8 compare"}, {32'd0, compare_o}, {32'd0, m_cmp});
    chk({tag, " R6 pend"}, {63'd0, timer_pend_o}, {63'd0, m_pend});
    chk({tag, " R9 irq"}, {56'd0, irq_pend_o}, {56'd0, exp_irq});
  endtask

  // apply inputs at negedge, model the edge, check at the next negedge
  task automatic step(string tag, logic av, logic [7:0] amt, logic cw, logic [31:0] cd,
                      logic pw, logic [31:0] pd, logic clr, logic [7:0] oth);
    logic set;
    adv_valid = av; adv_amt = amt; cnt_wr_en = cw; cnt_wr_data = cd;
    cmp_wr_en = pw; cmp_wr_data = pd; pend_clr = clr; irq_pend_i = oth;
    set = av && !cw && crosses(m_cnt, amt, m_cmp);
    @(posedge clk);
    if (av) m_cyc = m_cyc + {56'd0, amt};
    if (cw) m_cnt = cd;
    else if (av) m_cnt = m_cnt + {24'd0, amt};
    if (pw) m_cmp = pd;
    if (set) m_pend = 1'b1;
    else if (clr || pw) m_pend = 1'b0;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle();
    step("idle", 1'b0, 8'd0, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, irq_pend_i);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_cyc = '0; m_cnt = '0; m_cmp = '0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 reset");

    // R2 basic advance, old 0 == cmp 0 so no set (R5)
    step("R2 adv", 1'b1, 8'd5, 1'b0, 0, 1'b0, 0, 1'b0, 8'h00);
    step("R5 at cmp", 1'b1, 8'd200, 1'b0, 0, 1'b0, 0, 1'b0, 8'h00);
    // R3 exact landing
    step("R8 cmp wr", 1'b0, 8'd0, 1'b1, 32'd100, 1'b1, 32'd110, 1'b0, 8'h00);
    step("R3 short", 1'b1, 8'd9, 1'b0, 0, 1'b0, 0, 1'b0, 8'h00);
    chk("R3 one short no pend", {63'd0, timer_pend_o}, 64'd0);
    step("R3 exact", 1'b1, 8'd1, 1'b0, 0, 1'b0, 0, 1'b0, 8'h00);
    chk("R3 exact pend", {63'd0, timer_pend_o}, 64'd1);
    step("R6 sticky", 1'b1, 8'd50, 1'b0, 0, 1'b0, 0, 1'b0, 8'h5A);
    step("R6 clr", 1'b0, 8'd0, 1'b0, 0, 1'b0, 0, 1'b1, 8'hFF);
    chk("R6 cleared", {63'd0, timer_pend_o}, 64'd0);
    // R4 wrap with new count below compare
    step("R4 setup", 1'b0, 8'd0, 1'b1, 32'hFFFF_FFF0, 1'b1, 32'hFFFF_FFFE, 1'b0, 8'h00);
    step("R4 wrap", 1'b1, 8'd40, 1'b0, 0, 1'b0, 0, 1'b0, 8'h00);
    chk("R4 wrap pend", {63'd0, timer_pend_o}, 64'd1);
    // R5 wrap with old >= cmp
    step("R5 setup", 1'b0, 8'd0, 1'b1, 32'hFFFF_FFF8, 1'b1, 32'h10, 1'b0, 8'h00);
    step("R5 wrap", 1'b1, 8'd255, 1'b0, 0, 1'b0, 0, 1'b0, 8'h00);
    chk("R5 no pend", {63'd0, timer_pend_o}, 64'd0);
    // R7 load collides with a crossing advance
    step("R7 setup", 1'b0, 8'd0, 1'b1, 32'd5, 1'b1, 32'd10, 1'b0, 8'h00);
    step("R7 collide", 1'b1, 8'd20, 1'b1, 32'd3, 1'b0, 0, 1'b0, 8'h00);
    chk("R7 count loaded", {32'd0, count_o}, 64'd3);
    chk("R7 no pend", {63'd0, timer_pend_o}, 64'd0);
    // R6 crossing wins over clear
    step("R6 win", 1'b1, 8'd20, 1'b0, 0, 1'b0, 0, 1'b1, 8'h00);
    chk("R6 set beats clr", {63'd0, timer_pend_o}, 64'd1);
    step("R6 cmp clears", 1'b0, 8'd0, 1'b0, 0, 1'b1, 32'd1000, 1'b0, 8'h00);
    chk("R6 cmp write clears", {63'd0, timer_pend_o}, 64'd0);
    idle();

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic cw, pw;
      logic [31:0] cd, pd;
      r = $urandom;
      cw = (r[3:0] == 4'd0);
      pw = (r[7:4] == 4'd0);
      cd = r[8] ? (32'hFFFF_FF00 | {24'd0, 8'($urandom)}) : {24'd0, 8'($urandom)};
      pd = r[9] ? (32'hFFFF_FF00 | {24'd0, 8'($urandom)}) : ({22'd0, 10'($urandom)});
      step("R3 R4 rnd", r[12:10] != 3'd0, 8'($urandom), cw, cd, pw, pd,
           r[19:15] == 5'd0, 8'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule